// File: doc/BRIEF.md
# Carrier-compare SVPWM gate generator

This block drives a three-phase bridge that has two DC sources, each of which can be disconnected from the bridge. It runs an up/down triangular carrier whose half-period is set in clock cycles. It compares the carrier with three per-phase compare values to get the upper-switch commands for phases a, b and c. The lower switch of each leg is the complement of its upper switch, with a settable dead time after every change. Two pairs of source-decoupling gates are decoded from the three-bit bridge state. The first pair connects source one during the one-switch-high active states. The second pair connects source two during the two-switch-high active states. Both pairs are open during the zero states.

The compare values and the mode are sampled only when the carrier reaches its valley, so each switching period uses one consistent set of references. In symmetric mode a period runs from all-off through the active states to all-on and back. In discontinuous mode the phase with the smallest compare value is held high for the whole period, so the all-off state never occurs. The dwell times and the sector are computed upstream; this block only receives the resulting compare values.

Top module: `svpwm_gate_gen`

## Requirements
- R1: The carrier counts up from 0 to `period` and back down to 0, so one switching period is 2·`period` clock cycles (`period` ≥ 2). In symmetric mode the command for a phase is high while carrier ≥ its latched compare value. A compare value of 0 keeps the command high, and a value above `period` keeps it low. The bridge gates follow the command two clock cycles after the carrier value that produced it.
- R2: The compare values and the mode are latched on the clock edge at which the carrier returns to 0, and also while `en` is low or `rst` is high. Changes at any other time have no effect until the next valley.
- R3: When the latched mode is 1 (discontinuous), the command of the phase with the smallest latched compare value is held high for the whole period. On a tie the lowest phase is chosen, in the order a, b, c. Mode 0 is symmetric.
- R4: Each leg drives the upper gate equal to its command and the lower gate equal to its inverse. After any change of the command, both gates of that leg are low for max(`dead`,1) cycles, and then they follow the new command.
- R5: The state is taken as (phase a, phase b, phase c). When exactly one phase command is high (100, 010, 001), the source-one pair (`g_s7a`/`g_s7b`) is on. When exactly two are high (110, 011, 101), the source-two pair (`g_s8a`/`g_s8b`) is on.
- R6: For the states 000 and 111, both decoupling pairs are off.
- R7: After any change of the decoded source selection (none, one or two), both decoupling pairs are off for max(`dead`,1) cycles before the new selection is driven. The two pairs are therefore never on in the same cycle.
- R8: The two gates of each decoupling pair are always equal.
- R9: Synchronous reset forces all ten gate outputs low and puts the carrier at 0, counting up. While `en` is low the same holds: all gates are low from the next clock edge, and the carrier restarts at its valley.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| mode | input | 1 | 0 symmetric, 1 discontinuous |
| period | input | CNT_W | Carrier peak value (half period in cycles) |
| dead | input | DT_W | Dead-time count in cycles |
| cmp_a | input | CNT_W | Compare value, phase a |
| cmp_b | input | CNT_W | Compare value, phase b |
| cmp_c | input | CNT_W | Compare value, phase c |
| g_s1 | output | 1 | Upper gate, phase a |
| g_s2 | output | 1 | Lower gate, phase a |
| g_s3 | output | 1 | Upper gate, phase b |
| g_s4 | output | 1 | Lower gate, phase b |
| g_s5 | output | 1 | Upper gate, phase c |
| g_s6 | output | 1 | Lower gate, phase c |
| g_s7a | output | 1 | Source-one decoupling gate A |
| g_s7b | output | 1 | Source-one decoupling gate B |
| g_s8a | output | 1 | Source-two decoupling gate A |
| g_s8b | output | 1 | Source-two decoupling gate B |

## Verification
The bench feeds directed compare sets that separate behaviours which ordinary references would hide:
- Distinct ordered values walk the full sequence of zero, odd, even and zero states.
- A zero compare and a compare above the peak pin a leg permanently on or off.
- Equal values make two legs switch together and make discontinuous mode resolve a tie.

Random runs then vary period, dead time and mode, and change the compare values in the middle of a period, so that valley-only latching can be told apart from direct use. Short drops of the enable show whether the carrier restarts and all gates are cleared. Every cycle, all ten gates are compared against a reference model built from the requirements.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;
  localparam int NUM_LEGS = 3;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ONE  = 2'd1,
    SRC_TWO  = 2'd2
  } src_sel_e;

  function automatic src_sel_e classify(input logic [NUM_LEGS-1:0] st);
    logic [1:0] ones;
    ones = 2'(st[0]) + 2'(st[1]) + 2'(st[2]);
    case (ones)
      2'd1:    classify = SRC_ONE;
      2'd2:    classify = SRC_TWO;
      default: classify = SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/svpwm_carrier.sv
module svpwm_carrier #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             load
);
  logic             up;
  logic [CNT_W-1:0] nxt;
  logic             nup;

  always_comb begin
    if (up) begin
      nxt = cnt + CNT_W'(1);
      nup = (nxt != period);
    end else begin
      nxt = cnt - CNT_W'(1);
      nup = (nxt == '0);
    end
  end

  assign load = rst || !en || (!up && nxt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      cnt <= nxt;
      up  <= nup;
    end
  end
endmodule

// File: rtl/svpwm_leg.sv
module svpwm_leg #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            cmd,
  input  logic [DT_W-1:0] dead,
  output logic            hi,
  output logic            lo
);
  logic            prev;
  logic [DT_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev <= 1'b0;
      hold <= '0;
      hi   <= 1'b0;
      lo   <= 1'b0;
    end else if (cmd != prev) begin
      prev <= cmd;
      hold <= dead;
      hi   <= 1'b0;
      lo   <= 1'b0;
    end else if (hold > DT_W'(1)) begin
      hold <= hold - DT_W'(1);
    end else begin
      hold <= '0;
      hi   <= cmd;
      lo   <= !cmd;
    end
  end
endmodule

// File: rtl/svpwm_decouple.sv
module svpwm_decouple
  import svpwm_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [NUM_LEGS-1:0] state,
  input  logic [DT_W-1:0]     dead,
  output logic                src1_on,
  output logic                src2_on
);
  src_sel_e        want;
  src_sel_e        prev;
  logic [DT_W-1:0] hold;

  assign want = classify(state);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      prev    <= SRC_NONE;
      hold    <= '0;
      src1_on <= 1'b0;
      src2_on <= 1'b0;
    end else if (want != prev) begin
      prev    <= want;
      hold    <= dead;
      src1_on <= 1'b0;
      src2_on <= 1'b0;
    end else if (hold > DT_W'(1)) begin
      hold <= hold - DT_W'(1);
    end else begin
      hold    <= '0;
      src1_on <= (want == SRC_ONE);
      src2_on <= (want == SRC_TWO);
    end
  end
endmodule

// File: rtl/svpwm_gate_gen.sv
module svpwm_gate_gen
  import svpwm_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mode,
  input  logic [CNT_W-1:0] period,
  input  logic [DT_W-1:0]  dead,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic [CNT_W-1:0] cmp_c,
  output logic             g_s1,
  output logic             g_s2,
  output logic             g_s3,
  output logic             g_s4,
  output logic             g_s5,
  output logic             g_s6,
  output logic             g_s7a,
  output logic             g_s7b,
  output logic             g_s8a,
  output logic             g_s8b
);
  logic [CNT_W-1:0]    cnt;
  logic                load;
  logic [CNT_W-1:0]    cmp_in [NUM_LEGS];
  logic [CNT_W-1:0]    cmp_q  [NUM_LEGS];
  logic                mode_q;
  logic [NUM_LEGS-1:0] clamp;
  logic [NUM_LEGS-1:0] raw;
  logic [NUM_LEGS-1:0] state_q;
  logic [NUM_LEGS-1:0] hi;
  logic [NUM_LEGS-1:0] lo;
  logic                src1_on;
  logic                src2_on;

  assign cmp_in[0] = cmp_a;
  assign cmp_in[1] = cmp_b;
  assign cmp_in[2] = cmp_c;

  svpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .period (period),
    .cnt    (cnt),
    .load   (load)
  );

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NUM_LEGS; i++) cmp_q[i] <= cmp_in[i];
      mode_q <= mode;
    end
  end

  // Smallest compare wins the clamp; ties go to the lowest phase.
  always_comb begin
    clamp = '0;
    if (cmp_q[0] <= cmp_q[1] && cmp_q[0] <= cmp_q[2]) clamp[0] = 1'b1;
    else if (cmp_q[1] <= cmp_q[2])                    clamp[1] = 1'b1;
    else                                              clamp[2] = 1'b1;
  end

  generate
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      assign raw[g] = (cnt >= cmp_q[g]) || (mode_q && clamp[g]);

      svpwm_leg #(.DT_W(DT_W)) u_leg (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cmd  (state_q[g]),
        .dead (dead),
        .hi   (hi[g]),
        .lo   (lo[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !en) state_q <= '0;
    else            state_q <= {raw[0], raw[1], raw[2]} == 3'b000 ? '0 : raw;
  end

  svpwm_decouple #(.DT_W(DT_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .state   (state_q),
    .dead    (dead),
    .src1_on (src1_on),
    .src2_on (src2_on)
  );

  assign g_s1  = hi[0];
  assign g_s2  = lo[0];
  assign g_s3  = hi[1];
  assign g_s4  = lo[1];
  assign g_s5  = hi[2];
  assign g_s6  = lo[2];
  assign g_s7a = src1_on;
  assign g_s7b = src1_on;
  assign g_s8a = src2_on;
  assign g_s8b = src2_on;
endmodule

// File: rtl/svpwm_gate_gen_chk.sv
module svpwm_gate_gen_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic g_s1,
  input logic g_s2,
  input logic g_s3,
  input logic g_s4,
  input logic g_s5,
  input logic g_s6,
  input logic g_s7a,
  input logic g_s7b,
  input logic g_s8a,
  input logic g_s8b
);
  // R4
  leg_no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(g_s1 && g_s2) && !(g_s3 && g_s4) && !(g_s5 && g_s6));

  // R4
  upper_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(g_s1) |-> !$past(g_s2));

  // R7
  src_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(g_s7a && g_s8a));

  // R7
  src_break_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(g_s8a) |-> !$past(g_s7a));

  // R8
  pair_match_chk: assert property (@(posedge clk) disable iff (rst)
    (g_s7a == g_s7b) && (g_s8a == g_s8b));

  // R9
  disable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !(g_s1 || g_s2 || g_s3 || g_s4 || g_s5 || g_s6 || g_s7a || g_s8a));
endmodule

bind svpwm_gate_gen svpwm_gate_gen_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .en    (en),
  .g_s1  (g_s1),
  .g_s2  (g_s2),
  .g_s3  (g_s3),
  .g_s4  (g_s4),
  .g_s5  (g_s5),
  .g_s6  (g_s6),
  .g_s7a (g_s7a),
  .g_s7b (g_s7b),
  .g_s8a (g_s8a),
  .g_s8b (g_s8b)
);

// File: tb/svpwm_gate_gen_bench.sv
`timescale 1ns/1ps
module svpwm_gate_gen_bench;
  localparam int CW = 12;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic          mode = 1'b0;
  logic [CW-1:0] period = 12'd10;
  logic [DW-1:0] dead = 8'd1;
  logic [CW-1:0] cmp_a = '0, cmp_b = '0, cmp_c = '0;
  logic g_s1, g_s2, g_s3, g_s4, g_s5, g_s6, g_s7a, g_s7b, g_s8a, g_s8b;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  svpwm_gate_gen #(.CNT_W(CW), .DT_W(DW)) u_svpwm_gate_gen (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .period(period), .dead(dead),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_c(cmp_c),
    .g_s1(g_s1), .g_s2(g_s2), .g_s3(g_s3), .g_s4(g_s4), .g_s5(g_s5), .g_s6(g_s6),
    .g_s7a(g_s7a), .g_s7b(g_s7b), .g_s8a(g_s8a), .g_s8b(g_s8b)
  );

  // Reference model written from the requirements.
  logic [CW-1:0] m_cnt;
  logic          m_up;
  logic [CW-1:0] m_cmp [3];
  logic          m_mode;
  logic [2:0]    m_st;
  logic [2:0]    m_prev, m_hi, m_lo;
  int            m_hold [3];
  int            m_src, m_sprev, m_shold;
  logic          m_s7, m_s8;

  function automatic int src_of(input logic [2:0] s);
    int n;
    n = int'(s[0]) + int'(s[1]) + int'(s[2]);
    return (n == 1) ? 1 : (n == 2) ? 2 : 0;
  endfunction

  task automatic m_load();
    m_cmp[0] = cmp_a; m_cmp[1] = cmp_b; m_cmp[2] = cmp_c; m_mode = mode;
  endtask

  task automatic m_clear();
    m_st = 0; m_prev = 0; m_hi = 0; m_lo = 0; m_sprev = 0; m_shold = 0;
    m_s7 = 0; m_s8 = 0; m_cnt = 0; m_up = 1;
    for (int i = 0; i < 3; i++) m_hold[i] = 0;
  endtask

  always @(posedge clk) begin
    logic [2:0] raw;
    int cl;
    // R1, R3: command from carrier and latched references
    cl = (m_cmp[0] <= m_cmp[1] && m_cmp[0] <= m_cmp[2]) ? 0 : (m_cmp[1] <= m_cmp[2]) ? 1 : 2;
    for (int i = 0; i < 3; i++) raw[i] = (m_cnt >= m_cmp[i]) || (m_mode && cl == i);
    if (rst || !en) begin
      m_clear();
      m_load();
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (m_st[i] != m_prev[i]) begin
          m_prev[i] = m_st[i]; m_hold[i] = int'(dead); m_hi[i] = 0; m_lo[i] = 0;
        end else if (m_hold[i] > 1) m_hold[i]--;
        else begin m_hold[i] = 0; m_hi[i] = m_st[i]; m_lo[i] = !m_st[i]; end
      end
      m_src = src_of(m_st);
      if (m_src != m_sprev) begin
        m_sprev = m_src; m_shold = int'(dead); m_s7 = 0; m_s8 = 0;
      end else if (m_shold > 1) m_shold--;
      else begin m_shold = 0; m_s7 = (m_src == 1); m_s8 = (m_src == 2); end
      m_st = raw;
      if (m_up) begin
        m_cnt = m_cnt + 1'b1;
        if (m_cnt == period) m_up = 0;
      end else begin
        m_cnt = m_cnt - 1'b1;
        if (m_cnt == 0) begin m_up = 1; m_load(); end
      end
    end
  end

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check(m_mode ? "R1 R2 R3 R4 bridge" : "R1 R2 R4 bridge",
          {4'b0, g_s1, g_s2, g_s3, g_s4, g_s5, g_s6},
          {4'b0, m_hi[0], m_lo[0], m_hi[1], m_lo[1], m_hi[2], m_lo[2]});
    check("R5 R6 R7 decouple", {8'b0, g_s7a, g_s8a}, {8'b0, m_s7, m_s8});
    check("R8 pair", {8'b0, g_s7b, g_s8b}, {8'b0, g_s7a, g_s8a});
    if (!en) check("R9 disabled", {g_s1, g_s2, g_s3, g_s4, g_s5, g_s6, g_s7a, g_s7b, g_s8a, g_s8b}, 10'b0);
  endtask

  task automatic run(input int n, input bit jitter);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check_all();
      if (jitter && ($urandom % 16) == 0) begin
        cmp_a = CW'($urandom % (int'(period) + 3));
        cmp_b = CW'($urandom % (int'(period) + 3));
        cmp_c = CW'($urandom % (int'(period) + 3));
        mode  = 1'($urandom % 2);
      end
      if (jitter && ($urandom % 97) == 0) dead = DW'($urandom % 5);
    end
  endtask

  task automatic segment(input int p, input int d, input int a, input int b, input int c,
                         input bit md, input int n, input bit jitter);
    @(negedge clk);
    check_all();
    en = 0;
    run(2, 0);
    period = CW'(p); dead = DW'(d); mode = md;
    cmp_a = CW'(a); cmp_b = CW'(b); cmp_c = CW'(c);
    run(1, 0);
    en = 1;
    run(n, jitter);
  endtask

  initial begin : wd
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_clear(); m_load();
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset", {g_s1, g_s2, g_s3, g_s4, g_s5, g_s6, g_s7a, g_s7b, g_s8a, g_s8b}, 10'b0);
    rst = 0;
    // R1: ordered distinct compares, symmetric sequence
    segment(12, 1, 3, 6, 9, 0, 120, 0);
    // R1: compare 0 pinned on, above peak pinned off
    segment(10, 2, 0, 11, 5, 0, 100, 0);
    // R3: discontinuous with tie between phases b and c
    segment(16, 3, 9, 4, 4, 1, 140, 0);
    // R4 R7: equal compares switch two legs together
    segment(9, 0, 5, 5, 2, 0, 80, 0);
    // R2: mid-period changes without jitter timing control
    segment(20, 1, 7, 12, 15, 0, 15, 0);
    cmp_a = 1; cmp_b = 2; cmp_c = 3; mode = 1;
    run(120, 0);
    for (int s = 0; s < 40; s++) begin
      int p;
      p = 8 + int'($urandom % 33);
      segment(p, int'($urandom % 5), int'($urandom % (p + 3)), int'($urandom % (p + 3)),
              int'($urandom % (p + 3)), 1'($urandom % 2), 60 + int'($urandom % 300), 1);
    end
    // R9: reset in the middle of a run
    @(negedge clk); rst = 1;
    run(2, 0);
    check("R9 reset mid-run", {g_s1, g_s2, g_s3, g_s4, g_s5, g_s6, g_s7a, g_s7b, g_s8a, g_s8b}, 10'b0);
    rst = 0;
    run(50, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule